// File: doc/BRIEF.md
# Run-Time Variable-Width CRC-32 Engine

This block keeps a running CRC-32 over a bit stream that arrives on a byte-wide port. In each enabled clock it takes 2, 4 or 8 bits of that port. A two-bit speed code picks the count, and the code may change from one clock to the next. Internally, one-bit update stages are chained in series. The state register loads the output of the second, fourth or eighth stage, so a slow link and a fast link share one datapath.

The same instance serves a transmitter and a receiver. On the transmit side, the host initialises the engine, streams the payload and reads `crc_out` as the frame check value. On the receive side, the payload and the received check value both go through the engine. The `match` flag then tells the controller whether the frame is intact.

Top module: `crc32_var_width`

## Requirements
- R1: The generator polynomial is 0x04C11DB7. The state starts at all ones, and `crc_out` follows the common CRC-32 convention: after initialising and feeding the ASCII bytes "123456789" at full width, `crc_out` is 0xCBF43926.
- R2: Speed code 2'b00 consumes `din[1:0]` per enabled clock, and `din[7:2]` has no effect on the result.
- R3: Speed code 2'b01 consumes `din[3:0]` per enabled clock, and `din[7:4]` has no effect on the result.
- R4: Speed codes 2'b10 and 2'b11 both consume all of `din[7:0]` per enabled clock.
- R5: Within a clock, bits enter the serial update lowest index first. A bit enters by XOR with state bit 31, the state shifts left by one, and the polynomial is applied when that XOR result is 1.
- R6: While `en` is low and `init` is low, the state and both outputs hold, whatever `din` and `speed` carry.
- R7: `init` high at a clock edge presets the state to 0xFFFFFFFF, so `crc_out` reads 0x00000000. `init` takes priority over `en`.
- R8: A synchronous active-low `rst_n` presets the state to 0xFFFFFFFF, overriding `init` and `en`.
- R9: `crc_out` is the one's complement of the state with its bits reversed (`crc_out[i]` = ~state[31-i]). It changes in the clock after the consuming edge.
- R10: `match` is high exactly when the state equals the residue 0xC704DD7B. This happens after a stream followed by its own `crc_out`, sent low byte first with each byte lowest bit first. Any corrupted check value leaves `match` low.
- R11: The speed code may change on any clock within a stream, and the result equals serial processing of the concatenated bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | Preset the state to all ones |
| en | input | 1 | Consume bits this clock |
| din | input | 8 | Data bits, lowest index consumed first |
| speed | input | 2 | Bits per clock: 00=2, 01=4, 10/11=8 |
| crc_out | output | 32 | Running check value (reflected, inverted state) |
| match | output | 1 | State equals the good-frame residue |

## Verification
The bench checks every stage at the ports one clock after each enabled edge. A wrong polynomial tap, a mis-ordered stage or a wrong multiplexer leg therefore shows as a `crc_out` mismatch right away, in the first clock that exercises the faulty path. A fault in the reversal or inversion shows on the first compare after initialisation. A wrong residue compare is caught only when a complete frame with its check value has been fed in: `match` then stays low instead of rising in the clock after the last chunk. Bits outside the selected width are filled with random values, so a multiplexer leg that taps too deep shows on the first narrow clock.

// File: rtl/crc32_vw_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, speed-code type and a reference step function
// used by the engine's assertions. Assumes a 32-bit CRC over an 8-bit port.
package crc32_vw_pkg;
    localparam int CRC_W  = 32;
    localparam int DATA_W = 8;
    localparam int SPD_W  = 2;
    localparam logic [CRC_W-1:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_PRESET  = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704_DD7B;

    typedef enum logic [SPD_W-1:0] {
        SPD_QUARTER = 2'b00,
        SPD_HALF    = 2'b01,
        SPD_FULL    = 2'b10,
        SPD_FULL_B  = 2'b11
    } speed_code_e;

    // Serial update over n bits, lowest index first (assertion reference).
    function automatic logic [CRC_W-1:0] crc_multi_step(
        input logic [CRC_W-1:0]  s,
        input logic [DATA_W-1:0] bits,
        input int                n
    );
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = s;
        for (int i = 0; i < n; i++) begin
            fb  = acc[CRC_W-1] ^ bits[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return acc;
    endfunction
endpackage

// File: rtl/crc32_bit_stage.sv
`timescale 1ns/1ps
// One-bit CRC update: shifts the state left by one and folds in the
// polynomial when the incoming bit differs from the state MSB.
// Assumes a non-reflected state; purely combinational.
module crc32_bit_stage #(
    parameter int              CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7
) (
    input  logic [CRC_W-1:0] s_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] s_out
);
    logic feedback;

    // Feedback bit and conditional polynomial fold.
    always_comb begin
        feedback = s_in[CRC_W-1] ^ bit_in;
        s_out    = {s_in[CRC_W-2:0], 1'b0} ^ (feedback ? POLY : '0);
    end
endmodule

// File: rtl/crc32_stage_chain.sv
`timescale 1ns/1ps
// Unrolled chain of DATA_W one-bit stages. Stage k consumes din[k] and the
// output of stage k-1; the chain exposes the outputs after a quarter, a half
// and all of the port width. Assumes DATA_W is a multiple of 4.
module crc32_stage_chain #(
    parameter int              CRC_W  = 32,
    parameter int              DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY  = 32'h04C1_1DB7
) (
    input  logic [CRC_W-1:0]  state_in,
    input  logic [DATA_W-1:0] din,
    output logic [CRC_W-1:0]  tap_lo,
    output logic [CRC_W-1:0]  tap_mid,
    output logic [CRC_W-1:0]  tap_hi
);
    localparam int TAP_LO  = DATA_W / 4;
    localparam int TAP_MID = DATA_W / 2;
    localparam int TAP_HI  = DATA_W;

    logic [DATA_W:0][CRC_W-1:0] link;

    // Chain head is the registered state.
    always_comb link[0] = state_in;

    for (genvar k = 0; k < DATA_W; k++) begin : g_stage
        crc32_bit_stage #(.CRC_W(CRC_W), .POLY(POLY)) u_stage (
            .s_in   (link[k]),
            .bit_in (din[k]),
            .s_out  (link[k+1])
        );
    end

    // Tap points offered to the width multiplexer.
    always_comb begin
        tap_lo  = link[TAP_LO];
        tap_mid = link[TAP_MID];
        tap_hi  = link[TAP_HI];
    end
endmodule

// File: rtl/crc32_tap_select.sv
`timescale 1ns/1ps
// Width multiplexer: chooses which chain tap becomes the next state from the
// speed code. Both upper codes select the full-width tap.
module crc32_tap_select
    import crc32_vw_pkg::*;
#(
    parameter int CRC_W = 32
) (
    input  logic [SPD_W-1:0] speed,
    input  logic [CRC_W-1:0] tap_lo,
    input  logic [CRC_W-1:0] tap_mid,
    input  logic [CRC_W-1:0] tap_hi,
    output logic [CRC_W-1:0] next_state
);
    // Speed-code decode to tap choice.
    always_comb begin
        unique case (speed_code_e'(speed))
            SPD_QUARTER: next_state = tap_lo;
            SPD_HALF:    next_state = tap_mid;
            default:     next_state = tap_hi;
        endcase
    end
endmodule

// File: rtl/crc32_out_format.sv
`timescale 1ns/1ps
// Output formatting: reflects and inverts the state into the check value and
// flags the good-frame residue. Purely combinational.
module crc32_out_format #(
    parameter int               CRC_W   = 32,
    parameter logic [CRC_W-1:0] RESIDUE = 32'hC704_DD7B
) (
    input  logic [CRC_W-1:0] state,
    output logic [CRC_W-1:0] crc_out,
    output logic             match
);
    for (genvar i = 0; i < CRC_W; i++) begin : g_reflect
        // Bit i of the check value comes from state bit CRC_W-1-i, inverted.
        always_comb crc_out[i] = ~state[CRC_W-1-i];
    end

    // Residue compare for receive checking.
    always_comb match = (state == RESIDUE);
endmodule

// File: rtl/crc32_var_width.sv
`timescale 1ns/1ps
// Top: CRC-32 engine consuming 2, 4 or 8 bits of din per enabled clock.
// Holds the state register; reset and init preset it to all ones.
// Assumes din and speed are stable around the clock edge.
module crc32_var_width
    import crc32_vw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    input  logic [SPD_W-1:0]  speed,
    output logic [CRC_W-1:0]  crc_out,
    output logic              match
);
    localparam int W_LO  = DATA_W / 4;
    localparam int W_MID = DATA_W / 2;

    logic [CRC_W-1:0] state_q;
    logic [CRC_W-1:0] tap_lo, tap_mid, tap_hi;
    logic [CRC_W-1:0] next_state;

    crc32_stage_chain #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(CRC_POLY)) u_chain (
        .state_in (state_q),
        .din      (din),
        .tap_lo   (tap_lo),
        .tap_mid  (tap_mid),
        .tap_hi   (tap_hi)
    );

    crc32_tap_select #(.CRC_W(CRC_W)) u_sel (
        .speed      (speed),
        .tap_lo     (tap_lo),
        .tap_mid    (tap_mid),
        .tap_hi     (tap_hi),
        .next_state (next_state)
    );

    // State register: reset, then init, then enabled update.
    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= CRC_PRESET;
        else if (init)  state_q <= CRC_PRESET;
        else if (en)    state_q <= next_state;
    end

    crc32_out_format #(.CRC_W(CRC_W), .RESIDUE(CRC_RESIDUE)) u_fmt (
        .state   (state_q),
        .crc_out (crc_out),
        .match   (match)
    );

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !en) |=> (state_q == $past(state_q)));

    // R7
    init_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (state_q == CRC_PRESET));

    // R2
    quarter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && en && speed == SPD_QUARTER) |=>
        (state_q == crc_multi_step($past(state_q), $past(din), W_LO)));

    // R5
    chain_compose_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_hi == crc_multi_step(tap_mid, din >> W_MID, DATA_W - W_MID));
endmodule

// File: tb/sim_crc32_var_width.sv
`timescale 1ns/1ps
module sim_crc32_var_width;
    logic        clk = 1'b0;
    logic        rst_n, init, en;
    logic [7:0]  din;
    logic [1:0]  speed;
    logic [31:0] crc_out;
    logic        match;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] ref_s;

    always #4 clk = ~clk;

    crc32_var_width u0 (
        .clk(clk), .rst_n(rst_n), .init(init), .en(en),
        .din(din), .speed(speed), .crc_out(crc_out), .match(match)
    );

    // Stimulus table: {speed, data}; "123456789" at full width (R1, R4).
    localparam logic [9:0] VEC [9] = '{
        {2'b10, 8'h31}, {2'b11, 8'h32}, {2'b10, 8'h33}, {2'b10, 8'h34},
        {2'b11, 8'h35}, {2'b10, 8'h36}, {2'b10, 8'h37}, {2'b11, 8'h38},
        {2'b10, 8'h39}
    };
    localparam logic [31:0] KNOWN_ANSWER = 32'hCBF43926;

    function automatic logic [31:0] ref_bit(input logic [31:0] s, input logic b);
        logic fb;
        fb = s[31] ^ b;
        return {s[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    endfunction

    function automatic int width_of(input logic [1:0] sp);
        return (sp == 2'b00) ? 2 : (sp == 2'b01) ? 4 : 8;
    endfunction

    function automatic logic [31:0] ref_crc(input logic [31:0] s);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = ~s[31-i];
        return r;
    endfunction

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check_val(tag, crc_out, ref_crc(ref_s));
        check_val({tag, " match"}, {31'b0, match}, {31'b0, ref_s == 32'hC704DD7B});
    endtask

    // Drive one clock; update model as the requirements define.
    task automatic cycle(input logic i_init, input logic i_en,
                         input logic [1:0] sp, input logic [7:0] d);
        init = i_init; en = i_en; speed = sp; din = d;
        @(negedge clk);
        if (i_init) ref_s = 32'hFFFFFFFF;
        else if (i_en)
            for (int i = 0; i < width_of(sp); i++) ref_s = ref_bit(ref_s, d[i]);
    endtask

    // Feed nbits of v in random-width chunks, upper port bits random.
    task automatic feed_stream(input logic [135:0] v, input int nbits, input string tag);
        int pos = 0;
        while (pos < nbits) begin
            int w;
            logic [1:0] sp;
            logic [7:0] d;
            int r = $urandom_range(0, 2);
            w = (r == 0) ? 2 : (r == 1) ? 4 : 8;
            while (w > nbits - pos) w = w / 2;
            sp = (w == 2) ? 2'b00 : (w == 4) ? 2'b01 : {1'b1, 1'($urandom_range(0, 1))};
            d = 8'($urandom);
            for (int i = 0; i < w; i++) d[i] = v[pos + i];
            cycle(1'b0, 1'b1, sp, d);
            check_state(tag);
            pos += w;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_v;
        rst_n = 1'b0; init = 1'b0; en = 1'b1; speed = 2'b10; din = 8'h5A;
        ref_s = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        // R8: reset overrides en with data present.
        check_val("R8 reset crc_out", crc_out, 32'h0);
        check_val("R8 reset match", {31'b0, match}, 32'h0);
        rst_n = 1'b1;
        cycle(1'b1, 1'b0, 2'b10, 8'h00);

        // R1 R4: table walk with per-step model compare and known answer.
        foreach (VEC[i]) begin
            cycle(1'b0, 1'b1, VEC[i][9:8], VEC[i][7:0]);
            check_state("R4 table step");
        end
        check_val("R1 known answer", crc_out, KNOWN_ANSWER);
        check_val("R9 reflected form", crc_out, ref_crc(ref_s));

        // R10: feed the check value low byte first.
        hold_v = crc_out;
        for (int b = 0; b < 4; b++) cycle(1'b0, 1'b1, 2'b10, hold_v[8*b +: 8]);
        check_val("R10 residue match", {31'b0, match}, 32'h1);
        check_state("R10 residue state");

        // R6: idle cycles with changing inputs hold the result.
        hold_v = crc_out;
        for (int i = 0; i < 6; i++) begin
            cycle(1'b0, 1'b0, 2'($urandom), 8'($urandom));
            check_val("R6 hold", crc_out, hold_v);
        end

        // R7: init wins over en.
        cycle(1'b1, 1'b1, 2'b10, 8'hA5);
        check_val("R7 init priority", crc_out, 32'h0);

        // R2 R5: two bits, order matters; upper bits ignored.
        cycle(1'b0, 1'b1, 2'b00, 8'hFD);
        check_state("R2 quarter ignore upper");
        cycle(1'b1, 1'b0, 2'b00, 8'h00);
        cycle(1'b0, 1'b1, 2'b00, 8'h02);
        check_state("R5 bit order");
        // R3: four bits, upper nibble ignored.
        cycle(1'b0, 1'b1, 2'b01, 8'hC6);
        check_state("R3 half ignore upper");
        cycle(1'b0, 1'b1, 2'b01, 8'h36);
        check_state("R3 half second");

        // R11: random mixing of widths, enables and occasional init.
        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom_range(0, 63) == 0), ($urandom_range(0, 5) != 0),
                  2'($urandom), 8'($urandom));
            check_state("R11 random stream");
        end

        // R10 R11: random frames with their own check value at random widths.
        for (int f = 0; f < 40; f++) begin
            logic [135:0] v;
            logic [31:0]  fcs;
            int nbytes = $urandom_range(1, 16);
            for (int j = 0; j < 17; j++) v[8*j +: 8] = 8'($urandom);
            cycle(1'b1, 1'b0, 2'b00, 8'h00);
            feed_stream(v, 8 * nbytes, "R11 frame data");
            fcs = crc_out;
            if (f % 5 == 4) fcs[$urandom_range(0, 31)] ^= 1'b1;
            feed_stream({104'b0, fcs}, 32, "R10 frame check");
            check_val("R10 frame verdict", {31'b0, match}, {31'b0, (f % 5 != 4)});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule